// File: doc/BRIEF.md
# Board Configuration Command Register Block

This block is a small memory-mapped register file for board-level system control. A host reaches it through a plain 32-bit register bus. The bus carries a byte offset, a write strobe and write data, and it returns registered read data one cycle after an offset is presented. Three registers form a configuration transaction interface:

- a free 32-bit data word;
- a command (control) word;
- a two-bit status word.

Writing the command word completes at once. The block compares the stored word against two fixed encodings, one for power-down and one for reboot. A match raises a one-cycle request pulse toward the board's power or reset logic. Each command write leaves "complete" in the status register, and a word that matches neither encoding also leaves "error".

A board-variant identifier input decides whether the configuration registers exist. On any variant other than the one this block serves, their offsets behave as unmapped locations. A legacy reset-control location reads as zero and ignores writes.

Top module: `brd_cfg_regs`

## Requirements
- R1: A synchronous active-high reset clears the data, command and status registers to zero. After reset, read data is zero and both request outputs are low.
- R2: The data register at offset 0xA0 stores all 32 bits of a write. Read data for an offset appears on `rd_data` in the cycle after the offset is presented.
- R3: A write to the command register at offset 0xA4 stores the write data with bits 19 and 18 forced to zero and all other bits kept. Reading 0xA4 returns the stored value.
- R4: Every command write sets the status register at offset 0xA8 to 1 (bit 0 = complete). If the stored command matches neither request encoding, the status is set to 3 (bit 1 = error as well).
- R5: A stored command of 0xC0800000 drives `pwr_off_req` high for exactly one cycle, the cycle after the write.
- R6: A stored command of 0xC0900000 drives `reboot_req` high for exactly one cycle, the cycle after the write. Because bits 19:18 are cleared before matching, a write of 0xC09C0000 also qualifies.
- R7: A write to the status register stores only bits 1:0 of the write data. A read returns the stored value.
- R8: Offset 0x40 (reset control) always reads zero, and writes to it change no register and raise no request.
- R9: When `board_id` is not 0x190, offsets 0xA0, 0xA4 and 0xA8 read zero. Writes to them change no register and raise no request. The stored contents reappear once the identifier returns to 0x190.
- R10: Any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| board_id | input | 12 | Board variant identifier |
| rd_data | output | 32 | Registered read data for the previous cycle's offset |
| pwr_off_req | output | 1 | One-cycle power-down request |
| reboot_req | output | 1 | One-cycle reboot request |

## Verification
The bench builds the block with its default parameters: 8-bit offsets, 32-bit data, a 12-bit identifier matching 0x190, and the standard power-down and reboot encodings. These defaults put the exact decode offsets within reach. They also cover the bit 19:18 masking that lets a write carrying those bits still match an encoding. The bench switches `board_id` to another variant at run time, which exercises the hidden-register path. It then switches the identifier back to show that the stored state survived.

// File: rtl/brd_cfg_pkg.sv
package brd_cfg_pkg;

  localparam logic [7:0] OFS_DATA = 8'hA0;
  localparam logic [7:0] OFS_CTRL = 8'hA4;
  localparam logic [7:0] OFS_STAT = 8'hA8;

  localparam int STAT_W   = 2;
  localparam int ST_DONE  = 0;
  localparam int ST_ERR   = 1;

  localparam int MASK_LO  = 18;
  localparam int NCMD     = 2;
  localparam int CMD_OFF  = 0;
  localparam int CMD_BOOT = 1;

  typedef struct packed {
    logic data;
    logic ctrl;
    logic stat;
  } cfg_sel_t;

endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec
  import brd_cfg_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          ID_W       = 12,
  parameter logic [11:0] VARIANT_ID = 12'h190
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ID_W-1:0]   board_id,
  output cfg_sel_t          sel
);

  logic present;

  always_comb begin
    present  = (board_id == ID_W'(VARIANT_ID));
    sel.data = present && (addr == ADDR_W'(OFS_DATA));
    sel.ctrl = present && (addr == ADDR_W'(OFS_CTRL));
    sel.stat = present && (addr == ADDR_W'(OFS_STAT));
  end

endmodule

// File: rtl/cfg_cmd_unit.sv
module cfg_cmd_unit
  import brd_cfg_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] OFF_WORD = 32'hC080_0000,
  parameter logic [31:0] BOOT_WORD = 32'hC090_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_ctrl,
  input  logic              we_stat,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [STAT_W-1:0] stat_q,
  output logic              off_req,
  output logic              boot_req
);

  localparam logic [DATA_W-1:0] KEEP_MASK = ~(DATA_W'(3) << MASK_LO);
  localparam logic [DATA_W-1:0] CMD_TAB [NCMD] = '{DATA_W'(OFF_WORD), DATA_W'(BOOT_WORD)};

  logic [DATA_W-1:0] masked;
  logic [NCMD-1:0]   hit;

  assign masked = wdata & KEEP_MASK;

  for (genvar i = 0; i < NCMD; i++) begin : g_match
    assign hit[i] = (masked == CMD_TAB[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      stat_q   <= '0;
      off_req  <= 1'b0;
      boot_req <= 1'b0;
    end else begin
      off_req  <= 1'b0;
      boot_req <= 1'b0;
      if (we_ctrl) begin
        ctrl_q          <= masked;
        stat_q          <= '0;
        stat_q[ST_DONE] <= 1'b1;
        stat_q[ST_ERR]  <= ~|hit;
        off_req         <= hit[CMD_OFF];
        boot_req        <= hit[CMD_BOOT];
      end else if (we_stat) begin
        stat_q <= wdata[STAT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
  import brd_cfg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  cfg_sel_t          sel,
  input  logic [DATA_W-1:0] data_q,
  input  logic [DATA_W-1:0] ctrl_q,
  input  logic [STAT_W-1:0] stat_q,
  output logic [DATA_W-1:0] rd_val
);

  always_comb begin
    rd_val = '0;
    unique case (1'b1)
      sel.data: rd_val = data_q;
      sel.ctrl: rd_val = ctrl_q;
      sel.stat: rd_val = DATA_W'(stat_q);
      default:  rd_val = '0;
    endcase
  end

endmodule

// File: rtl/brd_cfg_regs.sv
module brd_cfg_regs
  import brd_cfg_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 32,
  parameter int          ID_W       = 12,
  parameter logic [11:0] VARIANT_ID = 12'h190,
  parameter logic [31:0] OFF_WORD   = 32'hC080_0000,
  parameter logic [31:0] BOOT_WORD  = 32'hC090_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [ID_W-1:0]   board_id,
  output logic [DATA_W-1:0] rd_data,
  output logic              pwr_off_req,
  output logic              reboot_req
);

  cfg_sel_t          sel;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] ctrl_q;
  logic [STAT_W-1:0] stat_q;
  logic [DATA_W-1:0] rd_val;

  cfg_addr_dec #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .VARIANT_ID(VARIANT_ID)
  ) u_dec (
    .addr(bus_addr), .board_id(board_id), .sel(sel)
  );

  cfg_cmd_unit #(
    .DATA_W(DATA_W), .OFF_WORD(OFF_WORD), .BOOT_WORD(BOOT_WORD)
  ) u_cmd (
    .clk(clk), .rst(rst),
    .we_ctrl(bus_wr && sel.ctrl), .we_stat(bus_wr && sel.stat),
    .wdata(bus_wdata), .ctrl_q(ctrl_q), .stat_q(stat_q),
    .off_req(pwr_off_req), .boot_req(reboot_req)
  );

  cfg_rd_mux #(.DATA_W(DATA_W)) u_mux (
    .sel(sel), .data_q(data_q), .ctrl_q(ctrl_q), .stat_q(stat_q), .rd_val(rd_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      rd_data <= '0;
    end else begin
      rd_data <= rd_val;
      if (bus_wr && sel.data) data_q <= bus_wdata;
    end
  end

endmodule

// File: rtl/brd_cfg_chk.sv
module brd_cfg_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int ID_W   = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [ID_W-1:0]   board_id,
  input logic [DATA_W-1:0] rd_data,
  input logic              pwr_off_req,
  input logic              reboot_req,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [1:0]        stat_q
);

  logic on_board;
  logic ctrl_wr;
  logic cfg_space;
  assign on_board  = (board_id == ID_W'(12'h190));
  assign ctrl_wr   = bus_wr && on_board && (bus_addr == ADDR_W'(8'hA4));
  assign cfg_space = (bus_addr == ADDR_W'(8'hA0)) || (bus_addr == ADDR_W'(8'hA4)) ||
                     (bus_addr == ADDR_W'(8'hA8));

  p_ctrl_mask_r3: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (ctrl_q[19:18] == 2'b00));

  p_stat_done_r4: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> stat_q[0]);

  p_off_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    pwr_off_req |=> !pwr_off_req);

  p_off_cause_r5: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (pwr_off_req == (ctrl_q == 32'hC080_0000)));

  p_boot_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    reboot_req |=> !reboot_req);

  p_req_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(pwr_off_req && reboot_req));

  p_rstctl_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(8'h40)) |=> (rd_data == '0));

  p_hidden_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !on_board && cfg_space) |=> ($stable(ctrl_q) && $stable(stat_q) &&
                                            !pwr_off_req && !reboot_req));

  p_hidden_read_r9: assert property (@(posedge clk) disable iff (rst)
    (!on_board && cfg_space) |=> (rd_data == '0));

endmodule

bind brd_cfg_regs brd_cfg_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .board_id(board_id),
  .rd_data(rd_data), .pwr_off_req(pwr_off_req), .reboot_req(reboot_req),
  .ctrl_q(ctrl_q), .stat_q(stat_q)
);

// File: tb/tb_brd_cfg_regs.sv
`timescale 1ns/1ps
module tb_brd_cfg_regs;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [11:0] board_id;
  logic [31:0] rd_data;
  logic        pwr_off_req;
  logic        reboot_req;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  brd_cfg_regs dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .board_id(board_id), .rd_data(rd_data), .pwr_off_req(pwr_off_req), .reboot_req(reboot_req)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    logic        exp_off;
    logic        exp_boot;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'hA0, 32'h0,         32'h0,         1'b0, 1'b0, 8'd1},  // R1 data cleared
    '{1'b0, 8'hA4, 32'h0,         32'h0,         1'b0, 1'b0, 8'd1},  // R1 command cleared
    '{1'b0, 8'hA8, 32'h0,         32'h0,         1'b0, 1'b0, 8'd1},  // R1 status cleared
    '{1'b1, 8'hA0, 32'hDEADBEEF,  32'h0,         1'b0, 1'b0, 8'd2},  // R2 write
    '{1'b0, 8'hA0, 32'h0,         32'hDEADBEEF,  1'b0, 1'b0, 8'd2},  // R2 readback
    '{1'b1, 8'hA0, 32'h12345678,  32'h0,         1'b0, 1'b0, 8'd2},
    '{1'b0, 8'hA0, 32'h0,         32'h12345678,  1'b0, 1'b0, 8'd2},
    '{1'b1, 8'hA4, 32'hFFFFFFFF,  32'h0,         1'b0, 1'b0, 8'd3},  // R3 unknown cmd
    '{1'b0, 8'hA4, 32'h0,         32'hFFF3FFFF,  1'b0, 1'b0, 8'd3},  // R3 bits 19:18 cleared
    '{1'b0, 8'hA8, 32'h0,         32'h3,         1'b0, 1'b0, 8'd4},  // R4 complete+error
    '{1'b1, 8'hA8, 32'hFFFFFFFC,  32'h0,         1'b0, 1'b0, 8'd7},  // R7 low bits only
    '{1'b0, 8'hA8, 32'h0,         32'h0,         1'b0, 1'b0, 8'd7},
    '{1'b1, 8'hA4, 32'hC0800000,  32'h0,         1'b1, 1'b0, 8'd5},  // R5 power-down pulse
    '{1'b0, 8'hA8, 32'h0,         32'h1,         1'b0, 1'b0, 8'd4},  // R4 complete, R5 pulse gone
    '{1'b0, 8'hA4, 32'h0,         32'hC0800000,  1'b0, 1'b0, 8'd3},
    '{1'b1, 8'hA4, 32'hC09C0000,  32'h0,         1'b0, 1'b1, 8'd6},  // R6 masked match
    '{1'b0, 8'hA4, 32'h0,         32'hC0900000,  1'b0, 1'b0, 8'd6},  // R6 pulse gone
    '{1'b0, 8'hA8, 32'h0,         32'h1,         1'b0, 1'b0, 8'd4},
    '{1'b1, 8'hA8, 32'h00000006,  32'h0,         1'b0, 1'b0, 8'd7},  // R7
    '{1'b0, 8'hA8, 32'h0,         32'h2,         1'b0, 1'b0, 8'd7},
    '{1'b1, 8'h40, 32'hFFFFFFFF,  32'h0,         1'b0, 1'b0, 8'd8},  // R8 write ignored
    '{1'b0, 8'h40, 32'h0,         32'h0,         1'b0, 1'b0, 8'd8},  // R8 reads zero
    '{1'b0, 8'hA8, 32'h0,         32'h2,         1'b0, 1'b0, 8'd8},
    '{1'b0, 8'hA0, 32'h0,         32'h12345678,  1'b0, 1'b0, 8'd8},
    '{1'b0, 8'h44, 32'h0,         32'h0,         1'b0, 1'b0, 8'd10}, // R10
    '{1'b0, 8'hAC, 32'h0,         32'h0,         1'b0, 1'b0, 8'd10}, // R10
    '{1'b0, 8'h9C, 32'h0,         32'h0,         1'b0, 1'b0, 8'd10}  // R10
  };

  task automatic apply(input vec_t v);
    @(negedge clk);
    bus_wr    = v.wr;
    bus_addr  = v.addr;
    bus_wdata = v.wdata;
    @(posedge clk);
    #1;
    n_vec++;
    if ((!v.wr && rd_data !== v.exp_rd) || pwr_off_req !== v.exp_off ||
        reboot_req !== v.exp_boot) begin
      n_fail++;
      $display("FAIL R%0d addr=%h: rd=%h off=%b boot=%b, expected rd=%h off=%b boot=%b",
               v.req, v.addr, rd_data, pwr_off_req, reboot_req, v.exp_rd, v.exp_off, v.exp_boot);
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  function automatic vec_t mk(input logic wr, input logic [7:0] a, input logic [31:0] d,
                              input logic [31:0] e, input logic o, input logic b,
                              input logic [7:0] r);
    vec_t v;
    v.wr = wr; v.addr = a; v.wdata = d; v.exp_rd = e;
    v.exp_off = o; v.exp_boot = b; v.req = r;
    return v;
  endfunction

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; board_id = 12'h190;
    repeat (3) @(posedge clk);
    #1;
    n_vec++;
    if (rd_data !== 32'h0 || pwr_off_req || reboot_req) begin
      n_fail++;
      $display("FAIL R1 in reset: rd=%h off=%b boot=%b, expected 0 0 0",
               rd_data, pwr_off_req, reboot_req);
    end
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) apply(VECS[i]);

    // R5/R6 back-to-back commands give adjacent single pulses
    apply(mk(1'b1, 8'hA4, 32'hC0800000, 32'h0, 1'b1, 1'b0, 8'd5));
    apply(mk(1'b1, 8'hA4, 32'hC0900000, 32'h0, 1'b0, 1'b1, 8'd6));

    // R9: foreign board variant hides configuration registers
    board_id = 12'h178;
    apply(mk(1'b0, 8'hA0, 32'h0, 32'h0, 1'b0, 1'b0, 8'd9));
    apply(mk(1'b0, 8'hA4, 32'h0, 32'h0, 1'b0, 1'b0, 8'd9));
    apply(mk(1'b1, 8'hA4, 32'hC0800000, 32'h0, 1'b0, 1'b0, 8'd9));
    apply(mk(1'b1, 8'hA0, 32'h0, 32'h0, 1'b0, 1'b0, 8'd9));
    apply(mk(1'b1, 8'hA8, 32'h3, 32'h0, 1'b0, 1'b0, 8'd9));
    board_id = 12'h190;
    apply(mk(1'b0, 8'hA0, 32'h0, 32'h12345678, 1'b0, 1'b0, 8'd9));
    apply(mk(1'b0, 8'hA4, 32'h0, 32'hC0900000, 1'b0, 1'b0, 8'd9));
    apply(mk(1'b0, 8'hA8, 32'h0, 32'h1, 1'b0, 1'b0, 8'd9));

    // R1: reset mid-run clears state
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    apply(mk(1'b0, 8'hA0, 32'h0, 32'h0, 1'b0, 1'b0, 8'd1));
    apply(mk(1'b0, 8'hA4, 32'h0, 32'h0, 1'b0, 1'b0, 8'd1));
    apply(mk(1'b0, 8'hA8, 32'h0, 32'h0, 1'b0, 1'b0, 8'd1));

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule